// File: doc/BRIEF.md
# Page Half-Swap Fix-Up Engine

This engine repairs the contents of one 4096-byte page held in a local word-addressed buffer after the page has come back to a different physical frame. For every page index it keeps one remembered address bit: the value of bit 17 of the frame the page sat in when it was last recorded. A restore command compares that remembered bit with bit 17 of the page's new physical base address. When the two disagree, the engine walks the page in 128-byte chunks and exchanges the lower 64 bytes of each chunk with the upper 64 bytes. It then reports the page as dirty.

A save command only records bit 17 of the supplied physical address into the per-page table. A restore on a page that has never been saved leaves memory alone. The engine reaches the buffer through a single-port 32-bit RAM master port with one cycle of read latency. It stages each lower half in a 16-word holding store, so the exchange needs no second copy of the page. Commands use a start/busy/done handshake.

Top module: `page_half_swap`

## Requirements
- R1: After reset, busy_o, done_o, dirty_o and mem_en_o are all 0.
- R2: A command is accepted when start_i is 1 and busy_o is 0. With cmd_op_i = 0 (save), the table entry for page_idx_i takes phys_addr_i[17]: 1 when that bit is set, 0 when it is clear. The entry is marked as saved. done_o is 1 in the cycle after acceptance, and the command makes no memory access.
- R3: With cmd_op_i = 1 (restore), on a saved page whose entry differs from phys_addr_i[17], every chunk c (0..31) is rewritten. Word w (0..15) at address {page, c, 0, w} is exchanged with the word at {page, c, 1, w}.
- R4: A restore on a saved page whose entry equals phys_addr_i[17] writes no memory.
- R5: A restore on a page that has never been saved since reset writes no memory and does not report dirty.
- R6: dirty_o is 1 together with done_o exactly when the finishing command swapped the page. dirty_page_o then gives that page index.
- R7: Two swapping restores of the same page with the same address bit return the page to its original contents.
- R8: start_i is ignored while busy_o is 1. It starts no command and changes no table entry.
- R9: The engine makes at most one memory access per cycle, only while busy. Every address it issues is {page_idx, chunk(5 bits), half(1 bit), word(4 bits)} with the page of the current command. Read data is taken from mem_rdata_i one cycle after the read.
- R10: busy_o stays 1 from acceptance until done_o. done_o is a single-cycle pulse, after which busy_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request |
| cmd_op_i | input | 1 | 0 = save, 1 = restore |
| page_idx_i | input | 6 | Page index of the command |
| phys_addr_i | input | 40 | New physical base address of the page |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished, one cycle |
| dirty_o | output | 1 | The finishing command swapped the page |
| dirty_page_o | output | 6 | Page index of the finishing command |
| mem_en_o | output | 1 | Buffer access request |
| mem_we_o | output | 1 | Buffer write enable |
| mem_addr_o | output | 16 | Buffer word address |
| mem_wdata_o | output | 32 | Buffer write data |
| mem_rdata_i | input | 32 | Buffer read data, one cycle after the read |

## Verification
A corrupted table entry or valid flag shows up at the end of the next restore of that page. dirty_o then has the wrong value, and either a page that should stay intact gets scrambled or a stale page is left unswapped. A wrong holding-store entry or chunk counter damages only particular words, so every word of both buffer pages is compared against a model after each command. A mis-sequenced walk breaks the done pulse or the busy window within a few cycles of the fault.

// File: rtl/phs_pkg.sv
package phs_pkg;
  typedef enum logic [0:0] {
    OP_SAVE    = 1'b0,
    OP_RESTORE = 1'b1
  } phs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_LOAD_LO,
    ST_RD_HI,
    ST_WR_LO,
    ST_WR_HI,
    ST_DONE
  } phs_state_e;
endpackage

// File: rtl/phs_bitmap.sv
module phs_bitmap #(
  parameter int MAX_PAGES = 64,
  localparam int PIDX_W = $clog2(MAX_PAGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              save_en_i,
  input  logic [PIDX_W-1:0] save_idx_i,
  input  logic              save_bit_i,
  input  logic [PIDX_W-1:0] rd_idx_i,
  output logic              rd_bit_o,
  output logic              rd_vld_o
);
  logic [MAX_PAGES-1:0] bit_q;
  logic [MAX_PAGES-1:0] vld_q;

  for (genvar g = 0; g < MAX_PAGES; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        bit_q[g] <= 1'b0;
        vld_q[g] <= 1'b0;
      end else if (save_en_i && save_idx_i == PIDX_W'(g)) begin
        bit_q[g] <= save_bit_i;
        vld_q[g] <= 1'b1;
      end
    end
  end

  assign rd_bit_o = bit_q[rd_idx_i];
  assign rd_vld_o = vld_q[rd_idx_i];

  assert_save_stored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_en_i |=> (bit_q[$past(save_idx_i)] == $past(save_bit_i)) && vld_q[$past(save_idx_i)]);
endmodule

// File: rtl/phs_hold_buf.sv
module phs_hold_buf #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           slot_q[g] <= '0;
      else if (we_i && idx_i == IDX_W'(g))   slot_q[g] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[idx_i];
endmodule

// File: rtl/phs_walker.sv
module phs_walker
  import phs_pkg::*;
#(
  parameter int PIDX_W  = 6,
  parameter int CHUNK_W = 5,
  parameter int HALF_W  = 4,
  parameter int DATA_W  = 32,
  localparam int MEM_AW = PIDX_W + CHUNK_W + 1 + HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_i,
  input  logic [PIDX_W-1:0] page_i,
  input  logic              addr_bit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dirty_o,
  output logic [PIDX_W-1:0] page_o,
  output logic              save_en_o,
  input  logic              saved_bit_i,
  input  logic              saved_vld_i,
  output logic              hold_we_o,
  output logic [HALF_W-1:0] hold_idx_o,
  output logic [DATA_W-1:0] hold_wdata_o,
  input  logic [DATA_W-1:0] hold_rdata_i,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  localparam int HALF_WORDS = 1 << HALF_W;

  phs_state_e          state_q;
  logic [PIDX_W-1:0]   page_q;
  logic                bit_q;
  logic                dirty_q;
  logic [CHUNK_W-1:0]  chunk_q;
  logic [HALF_W:0]     cnt_q;
  logic [HALF_W-1:0]   word;
  logic                accept;

  assign word   = cnt_q[HALF_W-1:0];
  assign accept = (state_q == ST_IDLE) && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      bit_q   <= 1'b0;
      dirty_q <= 1'b0;
      chunk_q <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          page_q  <= page_i;
          bit_q   <= addr_bit_i;
          dirty_q <= 1'b0;
          chunk_q <= '0;
          cnt_q   <= '0;
          state_q <= (op_i == OP_SAVE) ? ST_DONE : ST_DECIDE;
        end
        ST_DECIDE: state_q <= (saved_vld_i && saved_bit_i != bit_q) ? ST_LOAD_LO : ST_DONE;
        ST_LOAD_LO: begin
          if (cnt_q == (HALF_W+1)'(HALF_WORDS)) begin
            cnt_q   <= '0;
            state_q <= ST_RD_HI;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_RD_HI: state_q <= ST_WR_LO;
        ST_WR_LO: state_q <= ST_WR_HI;
        ST_WR_HI: begin
          if (word == HALF_W'(HALF_WORDS - 1)) begin
            cnt_q <= '0;
            if (chunk_q == '1) begin
              dirty_q <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              chunk_q <= chunk_q + 1'b1;
              state_q <= ST_LOAD_LO;
            end
          end else begin
            cnt_q   <= cnt_q + 1'b1;
            state_q <= ST_RD_HI;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en_o     = 1'b0;
    mem_we_o     = 1'b0;
    mem_addr_o   = {page_q, chunk_q, 1'b0, word};
    mem_wdata_o  = mem_rdata_i;
    hold_we_o    = 1'b0;
    hold_idx_o   = word;
    hold_wdata_o = mem_rdata_i;
    unique case (state_q)
      ST_LOAD_LO: begin
        mem_en_o   = !cnt_q[HALF_W];
        hold_we_o  = (cnt_q != '0);
        hold_idx_o = word - 1'b1;
      end
      ST_RD_HI: begin
        mem_en_o   = 1'b1;
        mem_addr_o = {page_q, chunk_q, 1'b1, word};
      end
      ST_WR_LO: begin
        mem_en_o = 1'b1;
        mem_we_o = 1'b1;
      end
      ST_WR_HI: begin
        mem_en_o    = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {page_q, chunk_q, 1'b1, word};
        mem_wdata_o = hold_rdata_i;
      end
      default: ;
    endcase
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_DONE);
  assign dirty_o   = done_o && dirty_q;
  assign page_o    = page_q;
  assign save_en_o = accept && (op_i == OP_SAVE);

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_en_o);
  assert_hi_after_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o[HALF_W]) |->
      ($past(mem_we_o) && $past(mem_addr_o) == {mem_addr_o[MEM_AW-1:HALF_W+1], 1'b0, mem_addr_o[HALF_W-1:0]}));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o);
  assert_busy_held_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  assert_dirty_with_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dirty_o |-> done_o);
  assert_busy_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |-> !save_en_o);
endmodule

// File: rtl/page_half_swap.sv
module page_half_swap #(
  parameter int ADDR_W      = 40,
  parameter int SWAP_BIT    = 17,
  parameter int PAGE_BYTES  = 4096,
  parameter int CHUNK_BYTES = 128,
  parameter int DATA_W      = 32,
  parameter int MAX_PAGES   = 64,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int HALF_WORDS = CHUNK_BYTES / (2 * WORD_BYTES),
  localparam int CHUNKS     = PAGE_BYTES / CHUNK_BYTES,
  localparam int HALF_W     = $clog2(HALF_WORDS),
  localparam int CHUNK_W    = $clog2(CHUNKS),
  localparam int PIDX_W     = $clog2(MAX_PAGES),
  localparam int MEM_AW     = PIDX_W + CHUNK_W + 1 + HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmd_op_i,
  input  logic [PIDX_W-1:0] page_idx_i,
  input  logic [ADDR_W-1:0] phys_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              dirty_o,
  output logic [PIDX_W-1:0] dirty_page_o,
  output logic              mem_en_o,
  output logic              mem_we_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              save_en;
  logic              saved_bit, saved_vld;
  logic              hold_we;
  logic [HALF_W-1:0] hold_idx;
  logic [DATA_W-1:0] hold_wdata, hold_rdata;
  logic [PIDX_W-1:0] cur_page;

  phs_bitmap #(.MAX_PAGES(MAX_PAGES)) u_bitmap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .save_en_i  (save_en),
    .save_idx_i (page_idx_i),
    .save_bit_i (phys_addr_i[SWAP_BIT]),
    .rd_idx_i   (cur_page),
    .rd_bit_o   (saved_bit),
    .rd_vld_o   (saved_vld)
  );

  phs_hold_buf #(.DEPTH(HALF_WORDS), .DATA_W(DATA_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (hold_we),
    .idx_i   (hold_idx),
    .wdata_i (hold_wdata),
    .rdata_o (hold_rdata)
  );

  phs_walker #(
    .PIDX_W (PIDX_W),
    .CHUNK_W(CHUNK_W),
    .HALF_W (HALF_W),
    .DATA_W (DATA_W)
  ) u_walker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .op_i         (cmd_op_i),
    .page_i       (page_idx_i),
    .addr_bit_i   (phys_addr_i[SWAP_BIT]),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .dirty_o      (dirty_o),
    .page_o       (cur_page),
    .save_en_o    (save_en),
    .saved_bit_i  (saved_bit),
    .saved_vld_i  (saved_vld),
    .hold_we_o    (hold_we),
    .hold_idx_o   (hold_idx),
    .hold_wdata_o (hold_wdata),
    .hold_rdata_i (hold_rdata),
    .mem_en_o     (mem_en_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_rdata_i  (mem_rdata_i)
  );

  assign dirty_page_o = cur_page;

  assert_dirty_page_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(dirty_page_o));
endmodule

// File: tb/page_half_swap_test.sv
`timescale 1ns/1ps
module page_half_swap_test;
  localparam int PW = 6;
  localparam int AW = 16;
  localparam int BW = 2048;

  typedef struct packed {
    logic          dirty;
    logic [PW-1:0] page;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic op = 1'b0;
  logic [PW-1:0] page = '0;
  logic [39:0] phys = '0;
  logic busy, done, dirty;
  logic [PW-1:0] dpage;
  logic mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;

  logic [31:0] ram [BW];
  logic [31:0] model [BW];
  logic [31:0] orig [BW];
  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int stray = 0;

  always #4 clk = ~clk;

  page_half_swap uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_op_i(op),
    .page_idx_i(page), .phys_addr_i(phys),
    .busy_o(busy), .done_o(done), .dirty_o(dirty), .dirty_page_o(dpage),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  // buffer model: pages 2 and 3 only, one-cycle read latency
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[10:0]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[10:0]];
    end
  end

  always @(negedge clk) begin
    if (rst_n && mem_en && mem_addr[15:11] != 5'b00001) stray++;
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 unexpected done", 64'(dpage), 64'hx);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(dirty == e.dirty, "R6 dirty flag", 64'(dirty), 64'(e.dirty));
        check(dpage == e.page, "R6 done page", 64'(dpage), 64'(e.page));
      end
    end
  end

  task automatic cmp_mem(input string req);
    int bad = -1;
    for (int i = 0; i < BW; i++) if (ram[i] !== model[i] && bad < 0) bad = i;
    if (bad < 0) check(1'b1, req, 0, 0);
    else check(1'b0, req, 64'(ram[bad]), 64'(model[bad]));
  endtask

  task automatic swap_model(input logic [PW-1:0] p);
    for (int c = 0; c < 32; c++)
      for (int w = 0; w < 16; w++) begin
        int lo = {p[0], 10'(c * 32 + w)};
        logic [31:0] t = model[lo];
        model[lo] = model[lo + 16];
        model[lo + 16] = t;
      end
  endtask

  task automatic run_op(input logic o, input logic [PW-1:0] p, input logic [39:0] a,
                        input logic exp_dirty, input bit poke);
    q.push_back('{dirty: exp_dirty, page: p});
    start = 1'b1; op = o; page = p; phys = a;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", 64'(busy), 1);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1; op = 1'b0; page = 6'd3; phys = 40'h0_0002_0000;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R10 idle after done", 64'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < BW; i++) begin
      ram[i]   = 32'hC3A50000 ^ (i * 32'h9E3779B1);
      model[i] = ram[i];
      orig[i]  = ram[i];
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !dirty && !mem_en, "R1 reset outputs",
          64'({busy, done, dirty, mem_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op(1'b1, 6'd2, 40'h0_0002_0000, 1'b0, 0);
    cmp_mem("R5 never-saved page untouched");
    run_op(1'b0, 6'd2, 40'h0_0000_4000, 1'b0, 0);
    cmp_mem("R2 save makes no access");
    run_op(1'b1, 6'd2, 40'h0_0001_C000, 1'b0, 0);
    cmp_mem("R4 matching bit leaves page");
    run_op(1'b1, 6'd2, 40'h0_0006_2000, 1'b1, 1);
    swap_model(6'd2);
    cmp_mem("R3 half-swap of every chunk");
    run_op(1'b1, 6'd3, 40'h0_0000_0000, 1'b0, 0);
    cmp_mem("R8 save during busy was ignored");
    run_op(1'b1, 6'd2, 40'h0_0002_0000, 1'b1, 0);
    swap_model(6'd2);
    cmp_mem("R7 double swap restores");
    begin
      int bad = 0;
      for (int i = 0; i < BW; i++) if (ram[i] !== orig[i]) bad++;
      check(bad == 0, "R7 original contents", 64'(bad), 0);
    end
    run_op(1'b0, 6'd3, 40'hF_FFFF_F000, 1'b0, 0);
    run_op(1'b1, 6'd3, 40'h0_0000_1000, 1'b1, 0);
    swap_model(6'd3);
    cmp_mem("R2 saved one, restore zero swaps");
    run_op(1'b1, 6'd3, 40'h0_0003_0000, 1'b0, 0);
    cmp_mem("R4 saved one, restore one keeps");
    check(stray == 0, "R9 accesses confined to page", 64'(stray), 0);
    check(q.size() == 0, "R6 all completions seen", 64'(q.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule